// File: doc/BRIEF.md
# Direct/Indirect Access Window Decoder

This block sits on the data port of a serial-flash controller and classifies every memory-bus access that arrives there. One programmable window of the port's address space is mapped onto an on-chip staging SRAM (the indirect path). Every access outside that window is turned into a flash address and handed to the direct path, which reads or writes the flash itself.

Software sets three values over a small register bus:
- the window base, written as an absolute bus address;
- a size exponent, where the window spans 4·2^exp bytes because one SRAM word is 4 bytes;
- a direct-path enable bit.

Each accepted access produces a registered result one cycle later:
- a path flag;
- an SRAM word index on an indirect hit;
- a flash byte address on a direct hit;
- an error flag when the access misses the window while the direct path is off.

Top module: `xip_window_decoder`

## Requirements
- R1: After reset the base register reads 0xE000_0000 at offset 0x1C, the exponent register reads 4 at offset 0x80, and the configuration register at offset 0x00 reads 0 (direct path off, enable at bit 7). Unmapped offsets read 0.
- R2: A write of a value above 15 to the exponent register stores 15. A value of 0..15 is stored as written.
- R3: An access whose address A satisfies base ≤ A ≤ base + 4·2^exp − 1 sets `hit_ind` and no other path flag.
- R4: The window edges are exact. base + 4·2^exp − 1 is inside the window, while base + 4·2^exp and base − 1 are outside it.
- R5: On an indirect hit `sram_idx` equals ((A − base) >> 2) modulo 2^exp.
- R6: With bit 7 of the configuration register set, an access outside the window sets `hit_dir`, and `flash_addr` equals (A − 0xE000_0000) truncated to 28 bits.
- R7: With bit 7 clear, an access outside the window sets `acc_err` only. It never sets `hit_dir`, and `flash_addr` reads 0.
- R8: The value of bit 7 has no effect on the classification or `sram_idx` of an access that falls inside the window.
- R9: Results appear in the cycle after `acc_valid` and last one cycle. At most one of `hit_ind`, `hit_dir` and `acc_err` is high, and all three are low in a cycle that follows no access.
- R10: A register write changes only the register at the written offset. The base register stores all 32 bits as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| acc_valid | input | 1 | Data-port access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Absolute bus address of the access |
| hit_ind | output | 1 | Access routed to the staging SRAM |
| hit_dir | output | 1 | Access routed to flash |
| acc_err | output | 1 | Access rejected (outside window, direct path off) |
| res_write | output | 1 | Write flag of the decoded access |
| sram_idx | output | 15 | SRAM word index on an indirect hit |
| flash_addr | output | 28 | Flash byte address on a direct hit |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before traffic starts. They also assume that every `acc_addr` lies inside the data port, so that the 28-bit flash offset is meaningful. The stimulus draws addresses only from the port range and from points around the current window edges. It changes the base, the exponent and the enable bit only through register writes that are separated from accesses.

// File: rtl/xip_window_decoder.sv
`timescale 1ns/1ps
module xip_window_decoder #(
  parameter int AW          = 32,
  parameter int FAW         = 28,
  parameter int RAW         = 8,
  parameter int RANGE_MAX   = 15,
  parameter int RANGE_RST   = 4,
  parameter int DIR_BIT     = 7,
  parameter logic [AW-1:0]  PORT_BASE = 32'hE000_0000,
  parameter logic [AW-1:0]  BASE_RST  = 32'hE000_0000,
  parameter logic [RAW-1:0] OFS_CFG   = 8'h00,
  parameter logic [RAW-1:0] OFS_BASE  = 8'h1C,
  parameter logic [RAW-1:0] OFS_EXP   = 8'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic [AW-1:0]  acc_addr,
  output logic           hit_ind,
  output logic           hit_dir,
  output logic           acc_err,
  output logic           res_write,
  output logic [RANGE_MAX-1:0] sram_idx,
  output logic [FAW-1:0] flash_addr
);
  localparam int EW = $clog2(RANGE_MAX + 1);
  localparam int IW = RANGE_MAX;

  logic [AW-1:0] base_q;
  logic [EW-1:0] exp_q;
  logic          dir_en_q;

  wire [EW-1:0] exp_wr = (cfg_wdata > 32'(RANGE_MAX)) ? EW'(RANGE_MAX) : cfg_wdata[EW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= BASE_RST;
      exp_q    <= EW'(RANGE_RST);
      dir_en_q <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_addr == OFS_CFG)  dir_en_q <= cfg_wdata[DIR_BIT];
      if (cfg_addr == OFS_BASE) base_q   <= cfg_wdata[AW-1:0];
      if (cfg_addr == OFS_EXP)  exp_q    <= exp_wr;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFS_CFG)  cfg_rdata[DIR_BIT] = dir_en_q;
    if (cfg_addr == OFS_BASE) cfg_rdata = 32'(base_q);
    if (cfg_addr == OFS_EXP)  cfg_rdata = 32'(exp_q);
  end

  wire [AW-1:0] win_off   = acc_addr - base_q;
  wire [AW-1:0] win_bytes = AW'(4) << exp_q;
  wire          in_win    = (acc_addr >= base_q) && (win_off < win_bytes);
  wire [IW-1:0] idx_mask  = IW'((AW'(1) << exp_q) - AW'(1));
  wire [IW-1:0] idx_d     = IW'(win_off >> 2) & idx_mask;
  wire [AW-1:0] port_off  = acc_addr - PORT_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_ind    <= 1'b0;
      hit_dir    <= 1'b0;
      acc_err    <= 1'b0;
      res_write  <= 1'b0;
      sram_idx   <= '0;
      flash_addr <= '0;
    end else begin
      hit_ind    <= acc_valid && in_win;
      hit_dir    <= acc_valid && !in_win && dir_en_q;
      acc_err    <= acc_valid && !in_win && !dir_en_q;
      res_write  <= acc_valid && acc_write;
      sram_idx   <= (acc_valid && in_win) ? idx_d : '0;
      flash_addr <= (acc_valid && !in_win && dir_en_q) ? port_off[FAW-1:0] : '0;
    end
  end

  p_one_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ind, hit_dir, acc_err}));

  p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (hit_ind || hit_dir || acc_err));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !(hit_ind || hit_dir || acc_err));

  p_err_only_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !dir_en_q) |=> !hit_dir);

  p_exp_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFS_EXP && cfg_wdata > 32'(RANGE_MAX)) |=> (exp_q == EW'(RANGE_MAX)));

  p_idx_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ind |-> ((AW'(sram_idx) >> exp_q) == '0));

  p_flash_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_dir |-> (flash_addr == '0));
endmodule

// File: tb/sim_xip_window_decoder.sv
`timescale 1ns/1ps
module sim_xip_window_decoder;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic acc_valid = 0, acc_write = 0;
  logic [31:0] acc_addr = 0;
  logic hit_ind, hit_dir, acc_err, res_write;
  logic [14:0] sram_idx;
  logic [27:0] flash_addr;
  int total = 0, bad = 0;
  logic [31:0] m_base = 32'hE000_0000;
  int m_exp = 4;
  bit m_en = 0;

  always #4 clk = ~clk;

  xip_window_decoder u0 (.clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .acc_valid, .acc_write, .acc_addr, .hit_ind, .hit_dir, .acc_err, .res_write,
    .sram_idx, .flash_addr);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_window(logic [31:0] a);
    logic [32:0] lim = 33'(m_base) + (33'd4 << m_exp);
    return (33'(a) >= 33'(m_base)) && (33'(a) < lim);
  endfunction

  task automatic wr(logic [7:0] o, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = o; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
    if (o == 8'h1C) m_base = d;
    if (o == 8'h80) m_exp = (d > 15) ? 15 : int'(d);
    if (o == 8'h00) m_en = d[7];
  endtask

  task automatic rd(string req, logic [7:0] o, logic [31:0] exp);
    @(negedge clk); cfg_addr = o; #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic access(string req, logic [31:0] a, bit w);
    bit iw;
    logic [31:0] eidx, efl;
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_write = w;
    @(negedge clk);
    iw = in_window(a);
    eidx = iw ? (((a - m_base) >> 2) & ((32'd1 << m_exp) - 1)) : 0;
    efl = (!iw && m_en) ? ((a - 32'hE000_0000) & 32'h0FFF_FFFF) : 0;
    chk({req, " R3 ind"}, 32'(hit_ind), 32'(iw));
    chk({req, " R6 dir"}, 32'(hit_dir), 32'(!iw && m_en));
    chk({req, " R7 err"}, 32'(acc_err), 32'(!iw && !m_en));
    chk({req, " R5 idx"}, 32'(sram_idx), eidx);
    chk({req, " R6 flash"}, 32'(flash_addr), efl);
    chk({req, " R9 wr"}, 32'(res_write), 32'(w));
    acc_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1 base", 8'h1C, 32'hE000_0000);
    rd("R1 exp", 8'h80, 4);
    rd("R1 cfg", 8'h00, 0);
    rd("R1 unmapped", 8'h44, 0);
    // R9: no access, no result
    @(negedge clk);
    chk("R9 idle", {29'd0, hit_ind, hit_dir, acc_err}, 0);

    // R4 edges at reset window (64 bytes)
    access("R4 first", 32'hE000_0000, 0);
    access("R4 last", 32'hE000_003F, 1);
    access("R4 past", 32'hE000_0040, 0);
    // R10: base is stored as a full absolute address
    wr(8'h1C, 32'hE000_1000);
    rd("R10 base", 8'h1C, 32'hE000_1000);
    rd("R10 exp kept", 8'h80, 4);
    access("R4 below", 32'hE000_0FFF, 0);
    // R2: saturation
    wr(8'h80, 99);
    rd("R2 sat", 8'h80, 15);
    wr(8'h80, 2);
    rd("R2 plain", 8'h80, 2);
    access("R4 last e2", 32'hE000_100F, 0);
    access("R4 past e2", 32'hE000_1010, 0);
    // R6 direct enabled
    wr(8'h00, 32'h80);
    rd("R6 cfg", 8'h00, 32'h80);
    rd("R10 base kept", 8'h1C, 32'hE000_1000);
    access("R6 direct", 32'hE123_4567, 1);
    // R8: indirect unchanged by enable
    access("R8 ind en", 32'hE000_1008, 0);
    wr(8'h00, 0);
    access("R8 ind dis", 32'hE000_1008, 0);
    access("R7 rejected", 32'hE123_4567, 0);
    @(negedge clk);
    chk("R9 after", {29'd0, hit_ind, hit_dir, acc_err}, 0);

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      logic [31:0] a;
      if (k == 0) wr(8'h80, $urandom_range(0, 20));
      else if (k == 1) wr(8'h00, $urandom);
      else if (k == 2) wr(8'h1C, 32'hE000_0000 | ($urandom & 32'h07FF_FFFC));
      if ($urandom_range(0, 1) == 1) begin
        a = m_base + ($urandom % ((32'd4 << m_exp) + 8)) - 4;
        if (a < 32'hE000_0000) a = 32'hE000_0000;
      end else
        a = 32'hE000_0000 | ($urandom & 32'h0FFF_FFFF);
      access("R3 rand", a, 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule